// File: doc/BRIEF.md
# SDRAM Read Data Capture Aligner

This block sits on the controller side of an SDRAM interface and tells the capture logic when returning read data is valid. Each READ handed to the memory is also handed to this block as a one-cycle request strobe with a tag. The block holds a copy of the device's mode word. From that word it takes the CAS latency (2 or 3 clocks) and the burst length (1, 2, 4 or 8 beats).

For every beat it raises a capture enable and presents the tag of the read that owns the beat. One cycle before the first beat of each burst it pulses an early indicator, which marks the cycle in which the device begins driving the data bus. Reads may be issued while an earlier burst is still in flight. A later READ cuts the earlier burst short, and its own data begins its latency after its command.

Mode words with a latency or burst-length code the block does not support raise an error flag and silence all capture outputs. The mode copy may only be rewritten while no read is outstanding. A rewrite attempted at any other time is dropped and flagged.

Top module: `rd_capture_align`

## Requirements
- R1: The latency is taken from mode word bits 6:4. Code 010 selects 2 clocks and code 011 selects 3 clocks. A mode word is accepted on the clock edge where `mode_load` is high.
- R2: For a read request sampled at edge n, `cap_en` first goes high just after edge n+CL-1, so that the capture flop registers the first beat at edge n+CL.
- R3: `dq_start` is high for exactly one cycle, just after edge n+CL-2. This is the cycle that ends at edge n+CL-1, one cycle before the first captured beat.
- R4: The burst length is taken from mode word bits 2:0. Code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `cap_en` stays high on that many consecutive cycles.
- R5: On every beat, `cap_tag` equals the tag given with the read that owns the beat.
- R6: A read whose first beat falls while an earlier burst is still returning ends the earlier burst. Its own beats begin CL cycles after its command and run for its full length.
- R7: A latency code other than 010 or 011, or a burst-length code with bit 2 set, drives `cfg_err` high. While `cfg_err` is high, neither `cap_en` nor `dq_start` is ever raised.
- R8: A `mode_load` while a read is outstanding leaves the mode copy unchanged and pulses `load_reject` for one cycle after that edge. A read is outstanding from the cycle of its request until the cycle of its last beat. A load while the block is idle does not pulse `load_reject`.
- R9: After reset, all outputs are low and the mode copy selects latency 2 with 1-beat bursts.
- R10: Mode word bits 3, 9 and 8:7 have no effect on capture timing or burst length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is registered on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | One-cycle strobe: a READ is registered by the device at this edge |
| rd_tag | input | TAG_W | Tag carried with the read |
| mode_load | input | 1 | Write strobe for the mode copy |
| mode_word | input | MODE_W | Mode word written to the device |
| cap_en | output | 1 | Capture the data bus at the next rising edge |
| cap_tag | output | TAG_W | Tag of the read owning the current beat |
| dq_start | output | 1 | Device starts driving the bus; first beat follows next cycle |
| cfg_err | output | 1 | Mode copy holds an unsupported latency or length code |
| load_reject | output | 1 | Pulse: the last mode load was dropped because a read was outstanding |

## Verification
The bench goes after three timing hazards. The first is an off-by-one in the latency tap: a design with that error shifts every beat and every early pulse one cycle and captures a neighbouring word. The second is a burst counter that miscounts or carries a stale tag, which shows up as a burst one beat too long or short or as beats labelled with the wrong read. The third is an overlapping read that does not take over the pipeline. A design with that fault would either finish the old burst over the new data or drop the new read.

The bench also loads a mode word while a read is in flight. A design that accepts that load retimes the running burst and the reads after it, and the bench sees this in the beat positions of the next read. Reserved codes are loaded to confirm that no capture enable escapes.

// File: rtl/rdcap_pkg.sv
// Package: shared constants and mode-field decoders for the read capture aligner.
// Assumes the latency field sits at bits 6:4 and the length field at bits 2:0.
package rdcap_pkg;
    localparam int CODE_W  = 3;
    localparam int LAT_LSB = 4;
    localparam int BL_LSB  = 0;
    localparam int MAX_CL  = 3;
    localparam int LAT_W   = $clog2(MAX_CL + 1);
    localparam int CNT_W   = 3;

    // Returns the latency in clocks, or zero for a reserved code.
    function automatic logic [LAT_W-1:0] lat_of(input logic [CODE_W-1:0] code);
        case (code)
            3'b010:  lat_of = LAT_W'(2);
            3'b011:  lat_of = LAT_W'(3);
            default: lat_of = '0;
        endcase
    endfunction

    // Returns burst length minus one for codes 000..011.
    function automatic logic [CNT_W-1:0] blm1_of(input logic [CODE_W-1:0] code);
        case (code[1:0])
            2'b00:   blm1_of = CNT_W'(0);
            2'b01:   blm1_of = CNT_W'(1);
            2'b10:   blm1_of = CNT_W'(3);
            default: blm1_of = CNT_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/rdcap_cfg.sv
// Module: rdcap_cfg
// Holds the controller's copy of the mode word and decodes latency and burst length.
// Assumes: busy covers every cycle in which a read is outstanding; loads then are dropped.
module rdcap_cfg
    import rdcap_pkg::*;
#(
    parameter int MODE_W = 12,
    parameter logic [MODE_W-1:0] RST_MODE = MODE_W'(12'h020)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_load,
    input  logic [MODE_W-1:0]   mode_word,
    input  logic                busy,
    output logic [LAT_W-1:0]    lat,
    output logic [CNT_W-1:0]    bl_m1,
    output logic                cfg_err,
    output logic                load_reject
);
    logic [MODE_W-1:0] mode_q;
    logic [LAT_W-1:0]  lat_raw;
    logic [CODE_W-1:0] bl_code;

    // Accept a new mode word only while idle; flag a dropped load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= RST_MODE;
            load_reject <= 1'b0;
        end else begin
            if (mode_load && !busy) mode_q <= mode_word;
            load_reject <= mode_load && busy;
        end
    end

    // Decode the two fields; fall back to latency 2 on a reserved code.
    always_comb begin
        lat_raw = lat_of(mode_q[LAT_LSB +: CODE_W]);
        bl_code = mode_q[BL_LSB +: CODE_W];
        bl_m1   = blm1_of(bl_code);
        cfg_err = (lat_raw == '0) || bl_code[CODE_W-1];
        lat     = (lat_raw == '0) ? LAT_W'(2) : lat_raw;
    end
endmodule

// File: rtl/rdcap_delay.sv
// Module: rdcap_delay
// Shift line of read requests and tags, tapped at CL-1 (burst launch) and CL-2 (bus drive start).
// Assumes: 2 <= lat <= MAX_CL.
module rdcap_delay
    import rdcap_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [LAT_W-1:0] lat,
    output logic             launch_vld,
    output logic [TAG_W-1:0] launch_tag,
    output logic             early_vld,
    output logic             busy
);
    localparam int DEPTH = MAX_CL - 1;
    localparam int NTAP  = 1 << LAT_W;

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [NTAP-1:0]  tap_v;
    logic [TAG_W-1:0] tap_t [NTAP];
    logic [LAT_W-1:0] launch_idx;
    logic [LAT_W-1:0] early_idx;

    assign tap_v[0] = rd_req;
    assign tap_t[0] = rd_tag;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        // Advance one request slot per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[k] <= 1'b0;
                tag_q[k] <= '0;
            end else begin
                vld_q[k] <= tap_v[k];
                tag_q[k] <= tap_t[k];
            end
        end
        assign tap_v[k+1] = vld_q[k];
        assign tap_t[k+1] = tag_q[k];
    end

    for (genvar k = DEPTH + 1; k < NTAP; k++) begin : g_pad
        assign tap_v[k] = 1'b0;
        assign tap_t[k] = '0;
    end

    // Pick the taps that match the programmed latency.
    always_comb begin
        launch_idx = lat - LAT_W'(1);
        early_idx  = lat - LAT_W'(2);
        launch_vld = tap_v[launch_idx];
        launch_tag = tap_t[launch_idx];
        early_vld  = tap_v[early_idx];
        busy       = |vld_q;
    end
endmodule

// File: rtl/rdcap_burst.sv
// Module: rdcap_burst
// Beat counter: a start loads the length and tag; a later start overrides a running burst.
// Assumes: bl_m1 is the burst length minus one.
module rdcap_burst
    import rdcap_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAG_W-1:0] start_tag,
    input  logic [CNT_W-1:0] bl_m1,
    output logic             cap_en,
    output logic [TAG_W-1:0] cap_tag,
    output logic             active
);
    logic [CNT_W-1:0] remain_q;

    // Issue one capture enable per beat, restarting on every launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en   <= 1'b0;
            cap_tag  <= '0;
            remain_q <= '0;
        end else if (start) begin
            cap_en   <= 1'b1;
            cap_tag  <= start_tag;
            remain_q <= bl_m1;
        end else if (remain_q != '0) begin
            cap_en   <= 1'b1;
            remain_q <= remain_q - CNT_W'(1);
        end else begin
            cap_en   <= 1'b0;
        end
    end

    assign active = (remain_q != '0);
endmodule

// File: rtl/rd_capture_align.sv
// Module: rd_capture_align (top)
// Aligns SDRAM read beats to their READ commands using the programmed latency and length.
// Assumes: rd_req is high for one cycle per READ the device registers at the same edge.
module rd_capture_align
    import rdcap_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cap_en,
    output logic [TAG_W-1:0]  cap_tag,
    output logic              dq_start,
    output logic              cfg_err,
    output logic              load_reject
);
    logic [LAT_W-1:0] lat_cyc;
    logic [CNT_W-1:0] bl_m1;
    logic             launch_vld;
    logic [TAG_W-1:0] launch_tag;
    logic             early_vld;
    logic             dly_busy;
    logic             burst_active;
    logic             burst_start;
    logic             any_busy;

    assign any_busy    = rd_req || dly_busy || burst_active;
    assign burst_start = launch_vld && !cfg_err;

    rdcap_cfg #(.MODE_W(MODE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .busy(any_busy), .lat(lat_cyc), .bl_m1(bl_m1), .cfg_err(cfg_err),
        .load_reject(load_reject)
    );

    rdcap_delay #(.TAG_W(TAG_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag), .lat(lat_cyc),
        .launch_vld(launch_vld), .launch_tag(launch_tag), .early_vld(early_vld),
        .busy(dly_busy)
    );

    rdcap_burst #(.TAG_W(TAG_W)) u_bst (
        .clk(clk), .rst_n(rst_n), .start(burst_start), .start_tag(launch_tag),
        .bl_m1(bl_m1), .cap_en(cap_en), .cap_tag(cap_tag), .active(burst_active)
    );

    // Register the bus drive-start pulse one cycle ahead of the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n) dq_start <= 1'b0;
        else        dq_start <= early_vld && !cfg_err;
    end
endmodule

// File: rtl/rd_capture_align_chk.sv
// Module: rd_capture_align_chk
// Temporal checks on the aligner, attached to every instance by the bind below.
module rd_capture_align_chk
    import rdcap_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             cap_en,
    input logic [TAG_W-1:0] cap_tag,
    input logic             dq_start,
    input logic             cfg_err,
    input logic             load_reject,
    input logic             start,
    input logic [LAT_W-1:0] lat
);
    AST_EARLY_THEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        dq_start |=> cap_en); // R3
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!cap_en && !dq_start)); // R7
    AST_REJECT_HOLDS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        load_reject |-> $stable(lat)); // R8
    AST_REJECT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_reject |-> $past(mode_load)); // R8
    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && $past(cap_en) && !$past(start)) |-> $stable(cap_tag)); // R5
endmodule

bind rd_capture_align rd_capture_align_chk #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .cap_en(cap_en),
    .cap_tag(cap_tag), .dq_start(dq_start), .cfg_err(cfg_err),
    .load_reject(load_reject), .start(burst_start), .lat(lat_cyc)
);

// File: tb/rd_capture_align_test.sv
// Bench for rd_capture_align: vector table of mode words, then directed corner cases.
module rd_capture_align_test;
    localparam int TAG_W = 4;
    localparam int NVEC  = 7;
    // {mode word, expected latency, expected burst length}
    localparam logic [19:0] VEC [NVEC] = '{
        {12'h020, 4'd2, 4'd1},
        {12'h022, 4'd2, 4'd4},
        {12'h031, 4'd3, 4'd2},
        {12'h033, 4'd3, 4'd8},
        {12'h023, 4'd2, 4'd8},
        {12'h030, 4'd3, 4'd1},
        {12'h3AA, 4'd2, 4'd4}
    };

    logic clk = 1'b0;
    logic rst_n, rd_req, mode_load;
    logic [TAG_W-1:0] rd_tag;
    logic [11:0] mode_word;
    logic cap_en, dq_start, cfg_err, load_reject;
    logic [TAG_W-1:0] cap_tag;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rd_capture_align uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag),
        .mode_load(mode_load), .mode_word(mode_word), .cap_en(cap_en),
        .cap_tag(cap_tag), .dq_start(dq_start), .cfg_err(cfg_err),
        .load_reject(load_reject)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_mode(input logic [11:0] w);
        mode_word = w;
        mode_load = 1'b1;
        tick();
        mode_load = 1'b0;
    endtask

    // One read, then count mismatches of beats, early pulse and tag over 16 cycles.
    task automatic run_read(input logic [TAG_W-1:0] t, input int cl, input int bl,
                            input string tagname);
        int bad_cap = 0;
        int bad_dq = 0;
        int bad_tag = 0;
        rd_req = 1'b1;
        rd_tag = t;
        for (int j = 0; j < 16; j++) begin
            tick();
            if (j == 0) rd_req = 1'b0;
            if (cap_en !== ((j >= cl - 1) && (j < cl - 1 + bl))) bad_cap++;
            if (dq_start !== (j == cl - 2)) bad_dq++;
            if (cap_en === 1'b1 && cap_tag !== t) bad_tag++;
        end
        check(bad_cap == 0, {tagname, " R2 R4 beat window"}, bad_cap, 0);
        check(bad_dq == 0, {tagname, " R3 early pulse"}, bad_dq, 0);
        check(bad_tag == 0, {tagname, " R5 beat tag"}, bad_tag, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int bad;
        rst_n = 1'b0; rd_req = 1'b0; rd_tag = '0; mode_load = 1'b0; mode_word = '0;
        repeat (3) tick();
        check(!cap_en && !dq_start && !cfg_err && !load_reject, "R9 outputs in reset",
              {cap_en, dq_start, cfg_err, load_reject}, 0);
        rst_n = 1'b1;
        tick();
        check(!cap_en && !dq_start && !cfg_err && !load_reject, "R9 outputs after reset",
              {cap_en, dq_start, cfg_err, load_reject}, 0);
        run_read(4'hC, 2, 1, "R9 default mode");

        // Table walk: R1 R4 R10 over several latency/length pairs.
        for (int i = 0; i < NVEC; i++) begin
            load_mode(VEC[i][19:8]);
            check(cfg_err == 1'b0, "R1 legal code accepted", cfg_err, 0);
            run_read(TAG_W'(i + 1), int'(VEC[i][7:4]), int'(VEC[i][3:0]), "R1 R10 vector");
        end

        // R6: second read mid-burst takes over at its own latency.
        load_mode(12'h033);
        bad = 0;
        rd_req = 1'b1; rd_tag = 4'h5;
        for (int j = 0; j < 16; j++) begin
            tick();
            rd_req = (j == 2);
            if (j == 2) rd_tag = 4'h9;
            if (cap_en !== (j >= 2 && j <= 12)) bad++;
            if (cap_en === 1'b1 && cap_tag !== ((j < 5) ? 4'h5 : 4'h9)) bad++;
            if (dq_start !== (j == 1 || j == 4)) bad++;
        end
        check(bad == 0, "R6 overlapping read truncates", bad, 0);

        // R7: reserved latency codes and a reserved length code.
        load_mode(12'h010);
        check(cfg_err == 1'b1, "R7 latency code 001 flagged", cfg_err, 1);
        bad = 0;
        rd_req = 1'b1; rd_tag = 4'h3;
        for (int j = 0; j < 12; j++) begin
            tick();
            rd_req = 1'b0;
            if (cap_en !== 1'b0 || dq_start !== 1'b0) bad++;
        end
        check(bad == 0, "R7 no capture on reserved latency", bad, 0);
        load_mode(12'h040);
        check(cfg_err == 1'b1, "R7 latency code 100 flagged", cfg_err, 1);
        load_mode(12'h024);
        check(cfg_err == 1'b1, "R7 length code 100 flagged", cfg_err, 1);
        bad = 0;
        rd_req = 1'b1;
        for (int j = 0; j < 12; j++) begin
            tick();
            rd_req = 1'b0;
            if (cap_en !== 1'b0 || dq_start !== 1'b0) bad++;
        end
        check(bad == 0, "R7 no capture on reserved length", bad, 0);

        // R8: idle load is accepted silently; a load mid-read is dropped.
        load_mode(12'h032);
        check(load_reject == 1'b0 && cfg_err == 1'b0, "R8 idle load accepted",
              {load_reject, cfg_err}, 0);
        bad = 0;
        rd_req = 1'b1; rd_tag = 4'h7;
        for (int j = 0; j < 12; j++) begin
            tick();
            rd_req = 1'b0;
            mode_load = (j == 0);
            mode_word = 12'h020;
            if (j == 1) check(load_reject == 1'b1, "R8 reject pulse", load_reject, 1);
            if (j == 2) check(load_reject == 1'b0, "R8 reject single cycle", load_reject, 0);
            if (cap_en !== (j >= 2 && j <= 5)) bad++;
        end
        check(bad == 0, "R8 running burst keeps latency", bad, 0);
        run_read(4'hA, 3, 4, "R8 setting retained");

        summary();
    end
endmodule